// File: doc/BRIEF.md
# MSI Doorbell Interrupt Register Bank

This block turns single-byte message-signalled interrupt writes into pending bits held in four status registers. A device posts one byte to a fixed doorbell address. The two low bits of the byte choose one of the four registers. The field from bit 2 upward gives an index, and the block sets one bit of the chosen register. Index 0 lands on the most significant valid bit. Each register drives its own level interrupt line, so each line can be routed to a different processor core. Software reads a register to see its pending vectors and clears them with a write-one-to-clear mask.

The parameter `IDX_W` sets the width of the index field:
- `IDX_W = 5` gives 32 vectors per register, using byte bits 6:2.
- `IDX_W = 3` gives 8 vectors per register, using byte bits 4:2. Across the four registers this is 32 vectors.

Bit 7 of the byte is never decoded. A doorbell whose index points past the valid range is dropped and latches a sticky error flag.

The error flag is a two-state machine:
- `ERR_IDLE` is the state after reset.
- The transition *bad-index* (an accepted doorbell with an out-of-range index) moves it to `ERR_LATCHED`.
- `ERR_LATCHED` has only the transition *hold* back to itself. Only reset returns it to `ERR_IDLE`.

Top module: `msi_doorbell_bank`

## Requirements
- R1: After reset every status register reads zero, every `irq_o` bit is low and `err_o` is low.
- R2: The doorbell byte bits 1:0 select the target register: value n sets a bit in register n only.
- R3: The index is byte bits 6:2 (bits 4:2 when `IDX_W`=3, with bits 6:5 required to be zero). The bit set is VEC-1-index, where VEC = 2**`IDX_W`. For example, index 0 sets bit VEC-1.
- R4: A doorbell accepted at a clock edge is visible on `rd_data` in the cycle after that edge. Status bits never become set without a doorbell.
- R5: `irq_o[n]` is high exactly while register n holds any set bit.
- R6: A clear (`clr_valid`=1) clears in register `clr_sel` the bits that are one in `clr_mask` and leaves all other bits unchanged.
- R7: When a doorbell set and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: A doorbell whose index is at least VEC changes no register and sets `err_o`. `err_o` then stays high until reset.
- R9: A doorbell is taken only when `db_valid`=1 and `db_addr` equals `DB_ADDR`. Other addresses are ignored, and byte bit 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_valid | input | 1 | Doorbell write strobe |
| db_addr | input | ADDR_W | Doorbell write address |
| db_data | input | 8 | Message byte |
| clr_valid | input | 1 | Clear strobe |
| clr_sel | input | 2 | Register to clear |
| clr_mask | input | VEC | Write-one-to-clear mask |
| rd_sel | input | 2 | Register to read |
| rd_data | output | VEC | Pending bits of register `rd_sel` |
| irq_o | output | 4 | Level interrupt per register |
| err_o | output | 1 | Sticky out-of-range doorbell flag |

## Verification
The bench runs the narrow and wide variants side by side on the same stimulus, which exposes the reversed bit order and the narrow out-of-range case. It targets:
- Index 0 and the top index. A design that forgot the reversal would light bit 0 instead of the top bit.
- Set and clear of the same bit in the same cycle. A design with the wrong priority would drop the interrupt.
- Doorbells with bit 7 set or aimed at a wrong address. A sloppy decoder would set a spurious vector.
- The narrow index 8. A design that wrapped the index would set a bit where it should raise the error.

// File: rtl/msi_db_pkg.sv
`timescale 1ns/1ps
package msi_db_pkg;
    localparam int NUM_REGS = 4;
    localparam int SEL_W    = 2;
    localparam int MSG_W    = 8;
    localparam int IDX_LSB  = 2;
    localparam int FIELD_W  = 5;

    typedef enum logic {
        ERR_IDLE    = 1'b0,
        ERR_LATCHED = 1'b1
    } err_state_e;
endpackage

// File: rtl/msi_db_decode.sv
`timescale 1ns/1ps
module msi_db_decode
    import msi_db_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] DB_ADDR = '0,
    localparam int VEC = 1 << IDX_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           db_valid,
    input  logic [ADDR_W-1:0]              db_addr,
    input  logic [MSG_W-1:0]               db_data,
    output logic [NUM_REGS-1:0][VEC-1:0]   set_vec,
    output logic                           bad_idx
);
    logic               hit;
    logic [SEL_W-1:0]   sel;
    logic [FIELD_W-1:0] idx;
    logic               in_range;
    logic [VEC-1:0]     pos_oh;
    logic               unused_msb;

    assign hit        = db_valid && (db_addr == DB_ADDR);
    assign sel        = db_data[SEL_W-1:0];
    assign idx        = db_data[IDX_LSB +: FIELD_W];
    assign unused_msb = db_data[MSG_W-1];

    generate
        if (IDX_W >= FIELD_W) begin : g_full_field
            assign in_range = 1'b1;
        end else begin : g_short_field
            assign in_range = (idx[FIELD_W-1:IDX_W] == '0);
        end
    endgenerate

    always_comb begin
        for (int b = 0; b < VEC; b++) begin
            pos_oh[b] = in_range && (idx == FIELD_W'(VEC - 1 - b));
        end
    end

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_target
            assign set_vec[r] = (hit && (sel == SEL_W'(r))) ? pos_oh : '0;
        end
    endgenerate

    assign bad_idx = hit && !in_range;

    // R2: at most one vector in the whole bank is set by any doorbell
    a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(set_vec) <= 1);
    // R8: an out-of-range doorbell sets nothing
    a_r8_bad_sets_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        bad_idx |-> (set_vec == '0));
endmodule

// File: rtl/msi_db_status.sv
`timescale 1ns/1ps
module msi_db_status #(
    parameter int VEC = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [VEC-1:0] set_i,
    input  logic [VEC-1:0] clr_i,
    output logic [VEC-1:0] q_o,
    output logic           irq_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= (q_o & ~clr_i) | set_i;
    end

    assign irq_o = |q_o;

    // R4: every requested set is present the next cycle
    a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
    // R4: no bit rises without a set
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0) |=> ((q_o & ~$past(q_o)) == '0));
    // R6: cleared bits that were not also set are gone
    a_r6_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
    // R7: set beats clear on the same bit
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & set_i) != '0) |=> ((q_o & $past(clr_i & set_i)) == $past(clr_i & set_i)));
endmodule

// File: rtl/msi_db_err.sv
`timescale 1ns/1ps
module msi_db_err
    import msi_db_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bad_i,
    output logic err_o
);
    err_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ERR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_IDLE:    if (bad_i) state_d = ERR_LATCHED;
            ERR_LATCHED: state_d = ERR_LATCHED;
            default:     state_d = ERR_IDLE;
        endcase
    end

    always_comb begin
        err_o = 1'b0;
        unique case (state_q)
            ERR_IDLE:    err_o = 1'b0;
            ERR_LATCHED: err_o = 1'b1;
            default:     err_o = 1'b0;
        endcase
    end

    // R8: bad doorbell raises the flag next cycle
    a_r8_flag_rises: assert property (@(posedge clk) disable iff (!rst_n)
        bad_i |=> err_o);
    // R8: flag is sticky
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
endmodule

// File: rtl/msi_doorbell_bank.sv
`timescale 1ns/1ps
module msi_doorbell_bank
    import msi_db_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] DB_ADDR = '0,
    localparam int VEC = 1 << IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 db_valid,
    input  logic [ADDR_W-1:0]    db_addr,
    input  logic [MSG_W-1:0]     db_data,
    input  logic                 clr_valid,
    input  logic [SEL_W-1:0]     clr_sel,
    input  logic [VEC-1:0]       clr_mask,
    input  logic [SEL_W-1:0]     rd_sel,
    output logic [VEC-1:0]       rd_data,
    output logic [NUM_REGS-1:0]  irq_o,
    output logic                 err_o
);
    logic [NUM_REGS-1:0][VEC-1:0] set_vec;
    logic [NUM_REGS-1:0][VEC-1:0] clr_vec;
    logic [NUM_REGS-1:0][VEC-1:0] status;
    logic                         bad_idx;

    msi_db_decode #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DB_ADDR(DB_ADDR)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .db_valid(db_valid), .db_addr(db_addr), .db_data(db_data),
        .set_vec(set_vec), .bad_idx(bad_idx)
    );

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            assign clr_vec[r] = (clr_valid && (clr_sel == SEL_W'(r))) ? clr_mask : '0;
            msi_db_status #(.VEC(VEC)) u_stat (
                .clk(clk), .rst_n(rst_n),
                .set_i(set_vec[r]), .clr_i(clr_vec[r]),
                .q_o(status[r]), .irq_o(irq_o[r])
            );
        end
    endgenerate

    msi_db_err u_err (.clk(clk), .rst_n(rst_n), .bad_i(bad_idx), .err_o(err_o));

    assign rd_data = status[rd_sel];

    // R1: one cycle after reset nothing is pending
    a_r1_reset_clean: assert property (@(posedge clk)
        $past(!rst_n) |-> (irq_o == '0 && !err_o));
    // R5: an interrupt line rises only when a doorbell was accepted
    a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!db_valid) |=> ((irq_o & ~$past(irq_o)) == '0));
endmodule

// File: tb/sim_msi_doorbell_bank.sv
`timescale 1ns/1ps
module sim_msi_doorbell_bank;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] DBA = 4'h0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        db_valid = 1'b0;
    logic [3:0]  db_addr = '0;
    logic [7:0]  db_data = '0;
    logic        clr_valid = 1'b0;
    logic [1:0]  clr_sel = '0;
    logic [31:0] clr_mask = '0;
    logic [1:0]  rd_sel = '0;
    logic [7:0]  rd0;
    logic [31:0] rd1;
    logic [3:0]  irq0, irq1;
    logic        err0, err1;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_doorbell_bank #(.IDX_W(3), .ADDR_W(4), .DB_ADDR(DBA)) u0 (
        .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_addr(db_addr),
        .db_data(db_data), .clr_valid(clr_valid), .clr_sel(clr_sel),
        .clr_mask(clr_mask[7:0]), .rd_sel(rd_sel), .rd_data(rd0),
        .irq_o(irq0), .err_o(err0));

    msi_doorbell_bank #(.IDX_W(5), .ADDR_W(4), .DB_ADDR(DBA)) u1 (
        .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_addr(db_addr),
        .db_data(db_data), .clr_valid(clr_valid), .clr_sel(clr_sel),
        .clr_mask(clr_mask), .rd_sel(rd_sel), .rd_data(rd1),
        .irq_o(irq1), .err_o(err1));

    // behavioural reference: m0 narrow (8 vectors), m1 wide (32 vectors)
    logic [31:0] m0 [4];
    logic [31:0] m1 [4];
    logic        me0, me1;
    logic [31:0] snap0 [4];
    logic [31:0] snap1 [4];

    task automatic model_step(ref logic [31:0] m [4], ref logic me, input int vec);
        int idx, sel;
        idx = (int'(db_data) >> 2) & 31;
        sel = int'(db_data) & 3;
        for (int r = 0; r < 4; r++)
            if (clr_valid && int'(clr_sel) == r) m[r] = m[r] & ~clr_mask;
        if (db_valid && db_addr == DBA) begin
            if (idx < vec) m[sel] = m[sel] | (32'h1 << (vec - 1 - idx));
            else           me = 1'b1;
        end
        if (vec < 32)
            for (int r = 0; r < 4; r++) m[r] = m[r] & ((32'h1 << vec) - 1);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < 4; r++) begin m0[r] = '0; m1[r] = '0; end
            me0 = 1'b0; me1 = 1'b0;
        end else begin
            model_step(m0, me0, 8);
            model_step(m1, me1, 32);
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // compare every output against the model; call just after a falling edge
    task automatic compare_all();
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            snap0[s] = {24'h0, rd0};
            snap1[s] = rd1;
            chk(snap0[s], m0[s], "R2/R3/R4 narrow status vs model");
            chk(snap1[s], m1[s], "R2/R3/R4 wide status vs model");
        end
        for (int s = 0; s < 4; s++) begin
            chk({31'h0, irq0[s]}, {31'h0, m0[s] != 0}, "R5 narrow irq");
            chk({31'h0, irq1[s]}, {31'h0, m1[s] != 0}, "R5 wide irq");
        end
        chk({31'h0, err0}, {31'h0, me0}, "R8 narrow err");
        chk({31'h0, err1}, {31'h0, me1}, "R8 wide err");
    endtask

    task automatic idle_inputs();
        db_valid = 1'b0; db_addr = DBA; db_data = '0;
        clr_valid = 1'b0; clr_sel = '0; clr_mask = '0;
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic ring(input logic [7:0] d);
        idle_inputs();
        db_valid = 1'b1; db_data = d;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        for (int s = 0; s < 4; s++) begin
            chk(snap0[s], 32'h0, "R1 narrow reset status");
            chk(snap1[s], 32'h0, "R1 wide reset status");
        end
        chk({28'h0, irq0 | irq1}, 32'h0, "R1 reset irq");
        chk({31'h0, err0 | err1}, 32'h0, "R1 reset err");

        ring(8'h00);                                   // reg0 index0
        chk(snap0[0], 32'h0000_0080, "R3 narrow index 0 -> top bit");
        chk(snap1[0], 32'h8000_0000, "R3 wide index 0 -> top bit");
        chk({28'h0, irq0}, 32'h1, "R5 irq0 only");

        ring(8'h06);                                   // reg2 index1
        chk(snap0[2], 32'h0000_0040, "R2 narrow select reg2");
        chk(snap1[2], 32'h4000_0000, "R2 wide select reg2");
        chk(snap0[1] | snap0[3], 32'h0, "R2 other regs untouched");

        ring(8'h1F);                                   // reg3 index7
        chk(snap0[3], 32'h0000_0001, "R3 narrow top index -> bit0");
        chk(snap1[3], 32'h0100_0000, "R3 wide index7 -> bit24");

        ring(8'h89);                                   // bit7 set, reg1 index2
        chk(snap0[1], 32'h0000_0020, "R9 bit7 ignored narrow");
        chk(snap1[1], 32'h2000_0000, "R9 bit7 ignored wide");

        idle_inputs();                                 // wrong address
        db_valid = 1'b1; db_addr = 4'h1; db_data = 8'h01;
        step();
        chk(snap0[1], 32'h0000_0020, "R9 wrong address ignored");
        chk({31'h0, err0}, 32'h0, "R9 wrong address no error");

        ring(8'h21);                                   // reg1 index8
        chk(snap0[1], 32'h0000_0020, "R8 narrow out-of-range ignored");
        chk({31'h0, err0}, 32'h1, "R8 narrow error raised");
        chk(snap1[1], 32'h2080_0000, "R8 wide index8 valid -> bit23");
        chk({31'h0, err1}, 32'h0, "R8 wide no error");

        idle_inputs();                                 // partial clear reg1
        clr_valid = 1'b1; clr_sel = 2'd1; clr_mask = 32'h0080_0020;
        step();
        chk(snap0[1], 32'h0, "R6 narrow clear");
        chk(snap1[1], 32'h2000_0000, "R6 wide partial clear keeps others");
        chk(snap1[0], 32'h8000_0000, "R6 other register untouched");

        idle_inputs();                                 // set and clear collide
        db_valid = 1'b1; db_data = 8'h08;
        clr_valid = 1'b1; clr_sel = 2'd0; clr_mask = 32'hFFFF_FFFF;
        step();
        chk(snap0[0], 32'h0000_0020, "R7 narrow set wins");
        chk(snap1[0], 32'h2000_0000, "R7 wide set wins");

        idle_inputs();
        clr_valid = 1'b1; clr_sel = 2'd0; clr_mask = 32'hFFFF_FFFF;
        step();
        chk({31'h0, irq0[0]}, 32'h0, "R5 irq drops when empty");
        idle_inputs();
        repeat (3) step();
        chk({31'h0, err0}, 32'h1, "R8 error sticky");

        for (int i = 0; i < 32; i++) ring(8'((i << 2) | 2));   // sweep wide reg2
        chk(snap1[2], 32'hFFFF_FFFF, "R3 wide sweep fills reg2");

        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            db_valid  = lfsr[0];
            db_addr   = lfsr[3:1] == 3'd7 ? 4'h5 : DBA;
            db_data   = lfsr[15:8];
            clr_valid = lfsr[4] & lfsr[5];
            clr_sel   = lfsr[7:6];
            clr_mask  = {lfsr, lfsr ^ 16'h5A5A};
            step();
        end

        idle_inputs();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        for (int s = 0; s < 4; s++) chk(snap1[s] | snap0[s], 32'h0, "R1 second reset clears");
        chk({31'h0, err0}, 32'h0, "R1 second reset clears error");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule